// File: doc/BRIEF.md
# Privilege Mode and Trap Controller

This block owns the user/supervisor bit of the processor's machine-state word and screens every issued instruction against the privilege rules. An upstream decoder presents each instruction as a 4-bit class code plus a 10-bit special-purpose-register (SPR) number on a valid/ready issue port. In supervisor mode every accepted instruction is cleared to execute. In user mode a privileged instruction is blocked instead. The block then takes a program exception: it saves the machine-state word, drops to supervisor mode, sets a sticky syndrome bit and presents the handler address.

Interrupt requests share the same cycle-level arbiter. A critical request saves the state word into the critical save register. A non-critical external request saves it into the non-critical save register. Either request also holds the issue port off for that cycle (`iss_ready` low), so the decoder must keep its instruction stable until it is accepted. A return input reloads the state word from either save register. A load input writes a word supplied by the surrounding datapath, which is how software state-word writes and restores arrive.

Top module: `priv_trap_ctrl`

## Requirements
- R1: Bit `MODE_POS` (default 14) of `ms_word` is the mode bit: 1 is user mode and 0 is supervisor mode. `user_mode` mirrors it. After reset, `ms_word`, `srr_nc`, `srr_cr` and `esr_priv` are all 0.
- R2: Class codes 1 through 9, 12 and 13 are always privileged. They are, in order: data-cache line invalidate, data-cache congruence invalidate, data-cache debug read, instruction-cache congruence invalidate, instruction-cache debug read, device-control read, device-control write, state-word read, state-word write, return non-critical and return critical. Codes 0, 14 and 15 are never privileged.
- R3: Class 10 (SPR read) is privileged unless `iss_spr` is 1, 8, 9 or 260 to 263.
- R4: Class 11 (SPR write) is privileged unless `iss_spr` is 1, 8 or 9. SPRs 260 to 263 are privileged for writes.
- R5: `exec_ok` is high exactly when `iss_valid` and `iss_ready` are high and the instruction is not privileged-in-user-mode.
- R6: A privileged instruction accepted in user mode raises `take_prog` in that cycle. At the next edge `srr_nc` holds the previous `ms_word` and the mode bit is 0.
- R7: While `take_prog` is high, `handler_pc` equals `{vec_prefix, 16'h0700}`.
- R8: `esr_priv` is set by each program exception and is never cleared except by reset.
- R9: `crit_irq` raises `take_crit`. At the next edge `srr_cr` holds the previous `ms_word`, the mode bit is 0, and `srr_nc` is unchanged.
- R10: `ext_irq` without `crit_irq` raises `take_ext`. At the next edge `srr_nc` holds the previous `ms_word` and the mode bit is 0.
- R11: Priority runs from critical, to external, to program exception, to return, to load. At most one take strobe is high in a cycle. `iss_ready` is low whenever either request is high, and a held instruction neither executes nor traps.
- R12: `rfi_en` reloads `ms_word` at the next edge from `srr_cr` when `rfi_crit` is 1, or from `srr_nc` otherwise. This can restore user mode.
- R13: `ms_load_en` writes `ms_load_word` into `ms_word` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue slot holds an instruction |
| iss_ready | output | 1 | Issue slot accepted this cycle |
| iss_class | input | 4 | Instruction class code |
| iss_spr | input | 10 | SPR number for classes 10 and 11 |
| exec_ok | output | 1 | Accepted instruction may execute |
| crit_irq | input | 1 | Critical interrupt request |
| ext_irq | input | 1 | Non-critical external interrupt request |
| rfi_en | input | 1 | Return: restore state word from a save register |
| rfi_crit | input | 1 | Return source: 1 for critical, 0 for non-critical |
| ms_load_en | input | 1 | Load state word |
| ms_load_word | input | 32 | Word to load |
| vec_prefix | input | 16 | Vector prefix for the handler address |
| take_crit | output | 1 | Critical interrupt taken |
| take_ext | output | 1 | External interrupt taken |
| take_prog | output | 1 | Privileged-violation exception taken |
| handler_pc | output | 32 | Program exception handler address |
| ms_word | output | 32 | Machine-state word |
| user_mode | output | 1 | Current mode bit |
| srr_nc | output | 32 | Non-critical save register |
| srr_cr | output | 32 | Critical save register |
| esr_priv | output | 1 | Privileged-instruction syndrome bit |

## Verification
The hardest situation to reach is a three-way collision: a critical request, an external request and a privileged user-mode instruction all in one cycle. The state word at that moment must differ from both save registers, so that a write to the wrong register shows up. The bench first seeds `srr_nc` through an external interrupt. It then loads a second, distinct user word. Only after that does it raise both requests with a violating instruction held on the issue port. It then follows the same held instruction through the external request's cycle, after which the instruction is accepted and executes in the supervisor mode that the interrupt left behind.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic [3:0] {
    IC_PLAIN    = 4'd0,
    IC_DLINE    = 4'd1,
    IC_DCONG    = 4'd2,
    IC_DDBG     = 4'd3,
    IC_ICONG    = 4'd4,
    IC_IDBG     = 4'd5,
    IC_DEVRD    = 4'd6,
    IC_DEVWR    = 4'd7,
    IC_MSRD     = 4'd8,
    IC_MSWR     = 4'd9,
    IC_SPRRD    = 4'd10,
    IC_SPRWR    = 4'd11,
    IC_RETNC    = 4'd12,
    IC_RETCR    = 4'd13,
    IC_RSV14    = 4'd14,
    IC_RSV15    = 4'd15
  } iclass_e;

  localparam int unsigned CLS_W = 4;
endpackage

// File: rtl/ptc_class_check.sv
module ptc_class_check
  import ptc_pkg::*;
#(
  parameter int unsigned SPR_W      = 10,
  parameter int unsigned SPR_FXE    = 1,
  parameter int unsigned SPR_LNK    = 8,
  parameter int unsigned SPR_CNT    = 9,
  parameter int unsigned SPR_UG_LO  = 260,
  parameter int unsigned SPR_UG_NUM = 4
) (
  input  logic [CLS_W-1:0] cls,
  input  logic [SPR_W-1:0] spr,
  output logic             is_priv
);
  logic core_free;
  logic ug_hit;

  always_comb begin
    core_free = (spr == SPR_W'(SPR_FXE)) || (spr == SPR_W'(SPR_LNK)) ||
                (spr == SPR_W'(SPR_CNT));
    ug_hit = 1'b0;
    for (int k = 0; k < SPR_UG_NUM; k++) begin
      if (spr == SPR_W'(SPR_UG_LO + k)) ug_hit = 1'b1;
    end
  end

  always_comb begin
    unique case (iclass_e'(cls))
      IC_DLINE, IC_DCONG, IC_DDBG, IC_ICONG, IC_IDBG,
      IC_DEVRD, IC_DEVWR, IC_MSRD, IC_MSWR,
      IC_RETNC, IC_RETCR: is_priv = 1'b1;
      IC_SPRRD:           is_priv = !(core_free || ug_hit);
      IC_SPRWR:           is_priv = !core_free;
      default:            is_priv = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptc_arbiter.sv
module ptc_arbiter (
  input  logic crit_req,
  input  logic ext_req,
  input  logic viol_req,
  input  logic rfi_req,
  input  logic load_req,
  output logic slot_free,
  output logic g_crit,
  output logic g_ext,
  output logic g_prog,
  output logic g_rfi,
  output logic g_load
);
  always_comb begin
    slot_free = !(crit_req || ext_req);
    g_crit    = crit_req;
    g_ext     = ext_req && !crit_req;
    g_prog    = viol_req && slot_free;
    g_rfi     = rfi_req && slot_free && !viol_req;
    g_load    = load_req && slot_free && !viol_req && !rfi_req;
  end
endmodule

// File: rtl/ptc_state_regs.sv
module ptc_state_regs #(
  parameter int unsigned W        = 32,
  parameter int unsigned MODE_POS = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         g_crit,
  input  logic         g_ext,
  input  logic         g_prog,
  input  logic         g_rfi,
  input  logic         g_load,
  input  logic         rfi_crit,
  input  logic [W-1:0] load_word,
  output logic [W-1:0] ms_q,
  output logic [W-1:0] srr_nc_q,
  output logic [W-1:0] srr_cr_q,
  output logic         esr_q
);
  localparam logic [W-1:0] MODE_MASK = W'(1) << MODE_POS;

  logic [W-1:0] ms_sup;
  assign ms_sup = ms_q & ~MODE_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ms_q     <= '0;
      srr_nc_q <= '0;
      srr_cr_q <= '0;
      esr_q    <= 1'b0;
    end else begin
      if (g_crit) begin
        srr_cr_q <= ms_q;
        ms_q     <= ms_sup;
      end else if (g_ext || g_prog) begin
        srr_nc_q <= ms_q;
        ms_q     <= ms_sup;
      end else if (g_rfi) begin
        ms_q <= rfi_crit ? srr_cr_q : srr_nc_q;
      end else if (g_load) begin
        ms_q <= load_word;
      end
      if (g_prog) esr_q <= 1'b1;
    end
  end
endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
  import ptc_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter int unsigned MODE_POS = 14,
  parameter int unsigned SPR_W    = 10,
  parameter int unsigned PFX_W    = 16,
  parameter int unsigned VEC_OFF  = 32'h0700
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  output logic             iss_ready,
  input  logic [3:0]       iss_class,
  input  logic [SPR_W-1:0] iss_spr,
  output logic             exec_ok,
  input  logic             crit_irq,
  input  logic             ext_irq,
  input  logic             rfi_en,
  input  logic             rfi_crit,
  input  logic             ms_load_en,
  input  logic [W-1:0]     ms_load_word,
  input  logic [PFX_W-1:0] vec_prefix,
  output logic             take_crit,
  output logic             take_ext,
  output logic             take_prog,
  output logic [W-1:0]     handler_pc,
  output logic [W-1:0]     ms_word,
  output logic             user_mode,
  output logic [W-1:0]     srr_nc,
  output logic [W-1:0]     srr_cr,
  output logic             esr_priv
);
  localparam int unsigned OFF_W = W - PFX_W;

  logic is_priv;
  logic viol;
  logic g_rfi;
  logic g_load;

  ptc_class_check #(.SPR_W(SPR_W)) u_cls (
    .cls     (iss_class),
    .spr     (iss_spr),
    .is_priv (is_priv)
  );

  assign user_mode = ms_word[MODE_POS];
  assign viol      = iss_valid && user_mode && is_priv;

  ptc_arbiter u_arb (
    .crit_req  (crit_irq),
    .ext_req   (ext_irq),
    .viol_req  (viol),
    .rfi_req   (rfi_en),
    .load_req  (ms_load_en),
    .slot_free (iss_ready),
    .g_crit    (take_crit),
    .g_ext     (take_ext),
    .g_prog    (take_prog),
    .g_rfi     (g_rfi),
    .g_load    (g_load)
  );

  ptc_state_regs #(.W(W), .MODE_POS(MODE_POS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .g_crit    (take_crit),
    .g_ext     (take_ext),
    .g_prog    (take_prog),
    .g_rfi     (g_rfi),
    .g_load    (g_load),
    .rfi_crit  (rfi_crit),
    .load_word (ms_load_word),
    .ms_q      (ms_word),
    .srr_nc_q  (srr_nc),
    .srr_cr_q  (srr_cr),
    .esr_q     (esr_priv)
  );

  assign exec_ok    = iss_valid && iss_ready && !(user_mode && is_priv);
  assign handler_pc = {vec_prefix, OFF_W'(VEC_OFF)};
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
  parameter int unsigned W        = 32,
  parameter int unsigned MODE_POS = 14,
  parameter int unsigned PFX_W    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic             is_priv,
  input logic             exec_ok,
  input logic             crit_irq,
  input logic             ext_irq,
  input logic             take_crit,
  input logic             take_ext,
  input logic             take_prog,
  input logic [W-1:0]     handler_pc,
  input logic [PFX_W-1:0] vec_prefix,
  input logic [W-1:0]     ms_word,
  input logic             user_mode,
  input logic [W-1:0]     srr_nc,
  input logic [W-1:0]     srr_cr,
  input logic             esr_priv
);
  // R5
  blocked_user_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && user_mode && is_priv) |-> !exec_ok);

  // R6
  prog_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_prog |=> (srr_nc == $past(ms_word)) && !user_mode);

  // R7
  handler_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_prog |-> (handler_pc[W-1 -: PFX_W] == vec_prefix) && (handler_pc[15:0] == 16'h0700));

  // R8
  esr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (esr_priv || take_prog) |=> esr_priv);

  // R9
  crit_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_crit |=> (srr_cr == $past(ms_word)) && $stable(srr_nc) && !user_mode);

  // R10
  ext_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ext |=> (srr_nc == $past(ms_word)) && !user_mode);

  // R11
  one_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_crit, take_ext, take_prog}));

  // R11
  hold_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_irq || ext_irq) |-> (!iss_ready && !exec_ok && !take_prog));

  // R1
  reset_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !user_mode && !esr_priv);

  logic unused_ok;
  assign unused_ok = ^ms_word[MODE_POS];
endmodule

bind priv_trap_ctrl ptc_checker #(.W(W), .MODE_POS(MODE_POS), .PFX_W(PFX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_valid  (iss_valid),
  .iss_ready  (iss_ready),
  .is_priv    (is_priv),
  .exec_ok    (exec_ok),
  .crit_irq   (crit_irq),
  .ext_irq    (ext_irq),
  .take_crit  (take_crit),
  .take_ext   (take_ext),
  .take_prog  (take_prog),
  .handler_pc (handler_pc),
  .vec_prefix (vec_prefix),
  .ms_word    (ms_word),
  .user_mode  (user_mode),
  .srr_nc     (srr_nc),
  .srr_cr     (srr_cr),
  .esr_priv   (esr_priv)
);

// File: tb/sim_priv_trap_ctrl.sv
`timescale 1ns/1ps
module sim_priv_trap_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic        iss_ready;
  logic [3:0]  iss_class = '0;
  logic [9:0]  iss_spr = '0;
  logic        exec_ok;
  logic        crit_irq = 1'b0;
  logic        ext_irq = 1'b0;
  logic        rfi_en = 1'b0;
  logic        rfi_crit = 1'b0;
  logic        ms_load_en = 1'b0;
  logic [31:0] ms_load_word = '0;
  logic [15:0] vec_prefix = '0;
  logic        take_crit, take_ext, take_prog;
  logic [31:0] handler_pc, ms_word, srr_nc, srr_cr;
  logic        user_mode, esr_priv;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  priv_trap_ctrl u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_priv(input int cls, input int spr);
    bit rd_free = (spr == 1) || (spr == 8) || (spr == 9) || (spr >= 260 && spr <= 263);
    bit wr_free = (spr == 1) || (spr == 8) || (spr == 9);
    if ((cls >= 1 && cls <= 9) || cls == 12 || cls == 13) return 1'b1;
    if (cls == 10) return !rd_free;
    if (cls == 11) return !wr_free;
    return 1'b0;
  endfunction

  task automatic load_word(input logic [31:0] w);
    @(negedge clk);
    ms_load_en = 1'b1; ms_load_word = w;
    @(posedge clk); #2;
    ms_load_en = 1'b0;
  endtask

  localparam logic [31:0] UW = 32'h1234_4321;
  localparam logic [31:0] SW = 32'h0BAD_0F0E;

  task automatic try_instr(input bit um, input int cls, input int spr);
    logic [31:0] w;
    bit pv;
    w = um ? (UW ^ {22'd0, spr[9:0]} ) : (SW ^ {22'd0, spr[9:0]});
    w[14] = um;
    load_word(w);
    pv = um && exp_priv(cls, spr);
    @(negedge clk);
    iss_valid = 1'b1; iss_class = cls[3:0]; iss_spr = spr[9:0];
    vec_prefix = 16'hC000 ^ 16'(spr * 7 + cls);
    #2;
    if (cls == 10) chk(exec_ok == !pv, "R3 spr read exec_ok", {31'd0, exec_ok}, {31'd0, !pv});
    else if (cls == 11) chk(exec_ok == !pv, "R4 spr write exec_ok", {31'd0, exec_ok}, {31'd0, !pv});
    else if (um) chk(exec_ok == !pv, "R2 class exec_ok", {31'd0, exec_ok}, {31'd0, !pv});
    else chk(exec_ok == 1'b1, "R5 supervisor exec_ok", {31'd0, exec_ok}, 32'd1);
    chk(take_prog == pv, "R6 take_prog", {31'd0, take_prog}, {31'd0, pv});
    if (pv) chk(handler_pc == {vec_prefix, 16'h0700}, "R7 handler_pc", handler_pc, {vec_prefix, 16'h0700});
    @(posedge clk); #2;
    iss_valid = 1'b0;
    if (pv) begin
      chk(srr_nc == w, "R6 srr_nc saved", srr_nc, w);
      chk(user_mode == 1'b0, "R6 mode cleared", {31'd0, user_mode}, 32'd0);
      chk(esr_priv == 1'b1, "R8 esr set", {31'd0, esr_priv}, 32'd1);
    end else begin
      chk(ms_word == w, "R5 state unchanged", ms_word, w);
    end
  endtask

  initial begin
    int sweep_hi;
    repeat (3) @(posedge clk);
    #2;
    chk(ms_word == 0 && user_mode == 0, "R1 reset state word", ms_word, 32'd0);
    chk(srr_nc == 0 && srr_cr == 0, "R1 reset save regs", srr_nc | srr_cr, 32'd0);
    chk(esr_priv == 0, "R1 reset esr", {31'd0, esr_priv}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk(iss_ready == 1'b1, "R11 ready idle", {31'd0, iss_ready}, 32'd1);
    load_word(UW);
    chk(ms_word == UW, "R13 load", ms_word, UW);
    chk(user_mode == 1'b1, "R1 mode bit 14", {31'd0, user_mode}, 32'd1);
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 16; c++) begin
        sweep_hi = (c == 10 || c == 11) ? 1023 : 0;
        for (int s = 0; s <= sweep_hi; s++) try_instr(m[0], c, (sweep_hi == 0) ? c * 37 : s);
      end
    end
    chk(esr_priv == 1'b1, "R8 esr sticky after clean instrs", {31'd0, esr_priv}, 32'd1);

    // external interrupt with a violating instruction held
    load_word(UW);
    @(negedge clk);
    ext_irq = 1'b1; iss_valid = 1'b1; iss_class = 4'd9; iss_spr = '0;
    #2;
    chk(take_ext == 1 && take_crit == 0 && take_prog == 0, "R10 take_ext only",
        {29'd0, take_crit, take_ext, take_prog}, 32'b010);
    chk(iss_ready == 0 && exec_ok == 0, "R11 issue held", {30'd0, iss_ready, exec_ok}, 32'd0);
    @(posedge clk); #2;
    ext_irq = 1'b0; iss_valid = 1'b0;
    chk(srr_nc == UW, "R10 srr_nc saved", srr_nc, UW);
    chk(user_mode == 0, "R10 mode cleared", {31'd0, user_mode}, 32'd0);

    // three-way collision
    load_word(32'h5555_4AAA);
    @(negedge clk);
    crit_irq = 1'b1; ext_irq = 1'b1; iss_valid = 1'b1; iss_class = 4'd1;
    #2;
    chk(take_crit == 1 && take_ext == 0 && take_prog == 0, "R11 critical first",
        {29'd0, take_crit, take_ext, take_prog}, 32'b100);
    chk(iss_ready == 0, "R11 ready low", {31'd0, iss_ready}, 32'd0);
    @(posedge clk); #2;
    chk(srr_cr == 32'h5555_4AAA, "R9 srr_cr saved", srr_cr, 32'h5555_4AAA);
    chk(srr_nc == UW, "R9 srr_nc untouched", srr_nc, UW);
    chk(user_mode == 0, "R9 mode cleared", {31'd0, user_mode}, 32'd0);
    crit_irq = 1'b0;
    #2;
    chk(take_ext == 1 && take_prog == 0, "R11 external second",
        {30'd0, take_ext, take_prog}, 32'b10);
    @(posedge clk); #2;
    ext_irq = 1'b0;
    chk(srr_nc == 32'h5555_0AAA, "R10 srr_nc second save", srr_nc, 32'h5555_0AAA);
    #2;
    chk(exec_ok == 1 && take_prog == 0, "R5 held instr runs in supervisor",
        {30'd0, exec_ok, take_prog}, 32'b10);
    @(negedge clk); iss_valid = 1'b0;

    // returns
    @(negedge clk); rfi_en = 1'b1; rfi_crit = 1'b1;
    @(posedge clk); #2;
    chk(ms_word == 32'h5555_4AAA && user_mode == 1, "R12 restore critical", ms_word, 32'h5555_4AAA);
    rfi_crit = 1'b0;
    @(posedge clk); #2;
    rfi_en = 1'b0;
    chk(ms_word == 32'h5555_0AAA, "R12 restore non-critical", ms_word, 32'h5555_0AAA);
    chk(esr_priv == 1'b1, "R8 esr still set", {31'd0, esr_priv}, 32'd1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule